// File: doc/BRIEF.md
# Card Slot Power Sequencer

This block supervises the three supplies of one plug-in card slot: a high main rail, a low main rail and an auxiliary rail. Software or board logic requests the main pair and the auxiliary rail through two separate enable levels. The block turns a rail group on only on a fresh rising edge of its enable, and only once the standby domain reports that its power-on delay is over. It then watches each rail's current-limit, input-undervoltage and overtemperature flags. A fault opens that rail group's switch and is held in a latch that only its own enable going low can clear.

A diagnostic force-on input is active low and sensed by level. It drives all three switches on regardless of protection, except that the auxiliary switch still honours its own undervoltage lockout. While force-on is active, the power-good and fault outputs are released high. The status outputs keep reporting the real command and latch state, and a register bit can mask the force-on input completely.

All enable and force-on pins are resynchronised through two flops. The current-limit filter time is a count of clock cycles taken from a port.

Top module: `slot_pwr_ctrl`

## Requirements
- R1: During and straight after reset, all three switch enables and both status vectors are 0, and pwr_good_n and fault_n are 1.
- R2: A rising edge on main_en_in switches on rails 0 and 1 (switch_on bits [1:0]). A rising edge on aux_en_in switches on rail 2 (bit 2). Bit order is {aux, main-low, main-high}.
- R3: An enable edge seen while stby_por_done is 0 is ignored, and an enable held high afterwards does not turn its rails on.
- R4: Driving an enable low turns its rail group off.
- R5: A rail trips only after its current-limit flag has been high, with the rail on, for filter_cycles+1 consecutive clocks. Any low cycle restarts the count.
- R6: With filter_cycles equal to 0, a single cycle of current limit trips the rail.
- R7: An undervoltage, overtemperature or current-limit trip sets that rail's latch (fault_status bit). It turns the rail's group off and drives fault_n low.
- R8: main_en_in low clears only the latches of rails 0 and 1. aux_en_in low clears only the latch of rail 2. A cleared latch leaves the rail off until a new enable edge.
- R9: When main and auxiliary latches are both set, fault_n stays low until both enables have gone low.
- R10: pwr_good_n is 0 only when all three rails are commanded on and no latch is set.
- R11: With force_on_n low and force_mask 0, all switches are on despite faults, except rail 2, which stays off while its undervoltage flag is high. pwr_good_n and fault_n are both 1.
- R12: With force_mask at 1, force_on_n has no effect on any output.
- R13: rail_status and fault_status keep showing the real command and latch state while force-on is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_por_done | input | 1 | Standby supply valid and power-on delay over |
| force_mask | input | 1 | Register bit: 1 disables the force-on input |
| main_en_in | input | 1 | Main rail pair enable (asynchronous) |
| aux_en_in | input | 1 | Auxiliary rail enable (asynchronous) |
| force_on_n | input | 1 | Diagnostic force-on, active low (asynchronous) |
| filter_cycles | input | CNT_W | Current-limit filter time in clocks |
| ilim_flag | input | 3 | Per-rail current-limit flag |
| uv_flag | input | 3 | Per-rail input undervoltage flag |
| ot_flag | input | 3 | Per-rail overtemperature flag |
| switch_on | output | 3 | Per-rail switch enable |
| pwr_good_n | output | 1 | Power good, active low |
| fault_n | output | 1 | Fault, active low |
| rail_status | output | 3 | Real commanded rail state |
| fault_status | output | 3 | Real per-rail fault latches |

## Verification
Two things can happen in the same cycle: the force-on override of the switches, and a protection trip that sets a latch. The bench holds current limit on all rails while force-on is low. It then expects every switch on and both flags released, while fault_status fills up and rail_status drops to zero. A second case clears the main latches while the auxiliary latch is still set, and expects fault_n to stay low until the auxiliary enable also falls.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  localparam int NUM_RAILS    = 3;
  localparam int RAIL_MAIN_HI = 0;
  localparam int RAIL_MAIN_LO = 1;
  localparam int RAIL_AUX     = 2;
  typedef logic [NUM_RAILS-1:0] rail_vec_t;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/rail_breaker.sv
module rail_breaker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             clr_en,
  input  logic             ilim,
  input  logic             uv,
  input  logic             ot,
  input  logic [CNT_W-1:0] limit,
  output logic             flt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;
  logic             oc_trip;

  assign oc_trip = armed && ilim && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !ilim || !armed) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_en)                 flt <= 1'b0;
    else if (armed && (oc_trip || uv || ot)) flt <= 1'b1;
  end

  // R5: count restarts after any cycle without current limit
  a_r5_count_restart: assert property (@(posedge clk) disable iff (rst)
    !ilim |=> (cnt_q == '0));
  // R8: a low enable leaves the latch clear
  a_r8_latch_clear: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> !flt);
endmodule

// File: rtl/slot_pwr_ctrl.sv
module slot_pwr_ctrl
  import slot_pwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stby_por_done,
  input  logic             force_mask,
  input  logic             main_en_in,
  input  logic             aux_en_in,
  input  logic             force_on_n,
  input  logic [CNT_W-1:0] filter_cycles,
  input  logic [2:0]       ilim_flag,
  input  logic [2:0]       uv_flag,
  input  logic [2:0]       ot_flag,
  output logic [2:0]       switch_on,
  output logic             pwr_good_n,
  output logic             fault_n,
  output logic [2:0]       rail_status,
  output logic [2:0]       fault_status
);
  logic [2:0] sync_q;
  logic       main_s, aux_s, force_n_s;
  logic       main_prev, aux_prev;
  logic       main_cmd, aux_cmd;
  logic       force_act;
  rail_vec_t  flt;
  rail_vec_t  armed_v, clr_v;
  rail_vec_t  normal_on, forced_on;
  logic       main_flt, aux_flt;

  slot_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({force_on_n, aux_en_in, main_en_in}),
    .q_sync(sync_q)
  );
  assign main_s    = sync_q[0];
  assign aux_s     = sync_q[1];
  assign force_n_s = sync_q[2];

  assign main_flt  = flt[RAIL_MAIN_HI] | flt[RAIL_MAIN_LO];
  assign aux_flt   = flt[RAIL_AUX];
  assign force_act = !force_n_s && !force_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_prev <= 1'b0;
      aux_prev  <= 1'b0;
      main_cmd  <= 1'b0;
      aux_cmd   <= 1'b0;
    end else begin
      main_prev <= main_s;
      aux_prev  <= aux_s;
      if (!main_s || main_flt)                        main_cmd <= 1'b0;
      else if (main_s && !main_prev && stby_por_done) main_cmd <= 1'b1;
      if (!aux_s || aux_flt)                          aux_cmd  <= 1'b0;
      else if (aux_s && !aux_prev && stby_por_done)   aux_cmd  <= 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    if (r == RAIL_AUX) begin : g_aux
      assign armed_v[r] = aux_cmd;
      assign clr_v[r]   = aux_s;
    end else begin : g_main
      assign armed_v[r] = main_cmd;
      assign clr_v[r]   = main_s;
    end
    rail_breaker #(.CNT_W(CNT_W)) u_brk (
      .clk(clk), .rst(rst),
      .armed(armed_v[r]), .clr_en(clr_v[r]),
      .ilim(ilim_flag[r]), .uv(uv_flag[r]), .ot(ot_flag[r]),
      .limit(filter_cycles), .flt(flt[r])
    );
    assign normal_on[r] = armed_v[r] && !flt[r];
    if (r == RAIL_AUX) begin : g_faux
      assign forced_on[r] = !uv_flag[r];
    end else begin : g_fmain
      assign forced_on[r] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      switch_on    <= '0;
      pwr_good_n   <= 1'b1;
      fault_n      <= 1'b1;
      rail_status  <= '0;
      fault_status <= '0;
    end else begin
      switch_on    <= force_act ? forced_on : normal_on;
      pwr_good_n   <= force_act || !(main_cmd && aux_cmd && (flt == '0));
      fault_n      <= force_act || (flt == '0);
      rail_status  <= {aux_cmd, main_cmd, main_cmd};
      fault_status <= flt;
    end
  end

  // R3: nothing turns on before the standby supply is ready
  a_r3_wait_por: assert property (@(posedge clk) disable iff (rst)
    (!stby_por_done && !main_cmd) |=> !main_cmd);
  // R7: a main latch drops the main command
  a_r7_fault_off: assert property (@(posedge clk) disable iff (rst)
    main_flt |=> !main_cmd);
  // R10: power good implies every switch is on
  a_r10_pgood_rails: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_n |-> (switch_on == 3'b111));
  // R11: force-on releases both flags
  a_r11_force_release: assert property (@(posedge clk) disable iff (rst)
    force_act |=> (pwr_good_n && fault_n));
endmodule

// File: tb/slot_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module slot_pwr_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_por_done = 0, force_mask = 0, main_en_in = 0, aux_en_in = 0, force_on_n = 1;
  logic [CNT_W-1:0] filter_cycles = 8'd3;
  logic [2:0] ilim_flag = 0, uv_flag = 0, ot_flag = 0;
  logic [2:0] switch_on, rail_status, fault_status;
  logic pwr_good_n, fault_n;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  slot_pwr_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .stby_por_done(stby_por_done), .force_mask(force_mask),
    .main_en_in(main_en_in), .aux_en_in(aux_en_in), .force_on_n(force_on_n),
    .filter_cycles(filter_cycles), .ilim_flag(ilim_flag), .uv_flag(uv_flag),
    .ot_flag(ot_flag), .switch_on(switch_on), .pwr_good_n(pwr_good_n),
    .fault_n(fault_n), .rail_status(rail_status), .fault_status(fault_status)
  );

  typedef struct packed {
    logic       m, a, fn, fm, por;
    logic [2:0] uv, ot, il;
    logic [2:0] x_sw;
    logic       x_pg, x_fl;
    logic [2:0] x_st, x_fs;
  } step_t;

  localparam int NSTEP = 17;
  localparam step_t STEPS [NSTEP] = '{
    // m a fn fm por  uv     ot     il     sw     pg fl  st     fs
    '{1,1,1,0,0, 3'b000,3'b000,3'b000, 3'b000,1,1, 3'b000,3'b000}, // R3 edge before por
    '{1,1,1,0,1, 3'b000,3'b000,3'b000, 3'b000,1,1, 3'b000,3'b000}, // R3 held level
    '{0,0,1,0,1, 3'b000,3'b000,3'b000, 3'b000,1,1, 3'b000,3'b000},
    '{1,0,1,0,1, 3'b000,3'b000,3'b000, 3'b011,1,1, 3'b011,3'b000}, // R2 main
    '{1,1,1,0,1, 3'b000,3'b000,3'b000, 3'b111,0,1, 3'b111,3'b000}, // R2 aux, R10
    '{0,1,1,0,1, 3'b000,3'b000,3'b000, 3'b100,1,1, 3'b100,3'b000}, // R4
    '{1,1,1,0,1, 3'b000,3'b000,3'b000, 3'b111,0,1, 3'b111,3'b000}, // R10
    '{1,1,1,0,1, 3'b001,3'b000,3'b000, 3'b100,1,0, 3'b100,3'b001}, // R7 uv
    '{1,1,1,0,1, 3'b000,3'b000,3'b000, 3'b100,1,0, 3'b100,3'b001}, // R8 held
    '{1,1,1,0,1, 3'b000,3'b100,3'b000, 3'b000,1,0, 3'b000,3'b101}, // R7 ot
    '{0,1,1,0,1, 3'b000,3'b000,3'b000, 3'b000,1,0, 3'b000,3'b100}, // R8 R9
    '{0,0,1,0,1, 3'b000,3'b000,3'b000, 3'b000,1,1, 3'b000,3'b000}, // R9
    '{1,1,1,0,1, 3'b000,3'b000,3'b000, 3'b111,0,1, 3'b111,3'b000},
    '{1,1,0,0,1, 3'b000,3'b000,3'b111, 3'b111,1,1, 3'b000,3'b111}, // R11 R13
    '{1,1,0,0,1, 3'b100,3'b000,3'b000, 3'b011,1,1, 3'b000,3'b111}, // R11 aux lockout
    '{1,1,0,1,1, 3'b000,3'b000,3'b000, 3'b000,1,0, 3'b000,3'b111}, // R12
    '{0,0,1,0,1, 3'b000,3'b000,3'b000, 3'b000,1,1, 3'b000,3'b000}  // R8
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_out(input string req, input logic [2:0] sw, input logic pg,
                         input logic fl, input logic [2:0] st, input logic [2:0] fs);
    chk(req, "switch_on", switch_on, sw);
    chk(req, "pwr_good_n", pwr_good_n, pg);
    chk(req, "fault_n", fault_n, fl);
    chk(req, "rail_status", rail_status, st);
    chk(req, "fault_status", fault_status, fs);
  endtask

  task automatic pulse_ilim(input logic [2:0] v, input int n);
    ilim_flag = v;
    tick(n);
    ilim_flag = 3'b000;
  endtask

  initial begin
    tick(3);
    all_out("R1", 3'b000, 1, 1, 3'b000, 3'b000);
    rst = 1'b0;
    tick(1);
    all_out("R1", 3'b000, 1, 1, 3'b000, 3'b000);

    for (int s = 0; s < NSTEP; s++) begin
      main_en_in = STEPS[s].m; aux_en_in = STEPS[s].a; force_on_n = STEPS[s].fn;
      force_mask = STEPS[s].fm; stby_por_done = STEPS[s].por;
      uv_flag = STEPS[s].uv; ot_flag = STEPS[s].ot; ilim_flag = STEPS[s].il;
      tick(8);
      all_out($sformatf("step%0d", s), STEPS[s].x_sw, STEPS[s].x_pg, STEPS[s].x_fl,
              STEPS[s].x_st, STEPS[s].x_fs);
    end

    // R5: filter window with filter_cycles = 3
    main_en_in = 1; aux_en_in = 1;
    tick(8);
    all_out("R5", 3'b111, 0, 1, 3'b111, 3'b000);
    pulse_ilim(3'b001, 3); tick(1);
    pulse_ilim(3'b001, 3); tick(6);
    all_out("R5", 3'b111, 0, 1, 3'b111, 3'b000);
    pulse_ilim(3'b001, 4); tick(6);
    all_out("R5", 3'b100, 1, 0, 3'b100, 3'b001);

    // R6: zero filter time trips on one cycle
    main_en_in = 0; aux_en_in = 0; filter_cycles = 8'd0;
    tick(8);
    main_en_in = 1; aux_en_in = 1;
    tick(8);
    pulse_ilim(3'b100, 1); tick(6);
    all_out("R6", 3'b011, 1, 0, 3'b011, 3'b100);

    // R1: reset in mid-run returns to idle
    rst = 1'b1;
    tick(1);
    all_out("R1", 3'b000, 1, 1, 3'b000, 3'b000);
    rst = 1'b0;
    tick(2);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule